// File: doc/BRIEF.md
# Chip-Select Gated Command/Address Register

This block is a single clocked register stage on a memory command/address path. It takes the address, bank and command strobes that a controller drives and re-drives them one clock later toward the memory devices. The chip-select, clock-enable and termination-control bits are re-driven on every clock.

To save switching power, the address and command group updates only on clock edges where at least one rank is selected. On edges where no chip select is active, that group keeps its last value. A gating-enable input turns this behaviour off, so that every register loads on every edge.

An asynchronous active-low reset clears all state and drives every output LOW. A one-cycle load flag marks each cycle whose gated outputs were freshly loaded, so that a downstream checker can align to the command.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: With gate_en_i HIGH, a rising edge at which at least one bit of cs_n_i is 0 loads addr_i, bank_i, ras_n_i, cas_n_i and we_n_i into the matching outputs, which are visible after that edge.
- R2: With gate_en_i HIGH, a rising edge at which cs_n_i equals 4'b1111 leaves q_addr_o, q_bank_o, q_ras_n_o, q_cas_n_o and q_we_n_o unchanged.
- R3: The gated group loads when any single chip-select bit (bit 0, 1, 2 or 3) is 0 on its own.
- R4: With gate_en_i LOW, the gated group loads on every rising edge, including edges where cs_n_i is 4'b1111.
- R5: q_cs_n_o, q_cke_o and q_odt_o take the values of cs_n_i, cke_i and odt_i at every rising edge, whatever the chip selects and the gating enable are.
- R6: While rst_n is 0, every output, q_load_o included, is 0. This holds from the moment rst_n falls, without waiting for a clock edge.
- R7: After rst_n rises, the outputs stay 0 through the next rising edge. Capture begins on the third rising edge after the release.
- R8: q_load_o is 1 for the cycle following each edge at which the gated group loaded, and 0 for the cycle following an edge at which it held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_en_i | input | 1 | 1: gate the address/command group on the chip selects; 0: load every edge |
| cs_n_i | input | 4 | Active-low chip selects, one per rank |
| addr_i | input | 16 | Address bits |
| bank_i | input | 3 | Bank address bits |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| cke_i | input | 2 | Clock-enable bits |
| odt_i | input | 2 | Termination-control bits |
| q_cs_n_o | output | 4 | Registered chip selects |
| q_addr_o | output | 16 | Registered address |
| q_bank_o | output | 3 | Registered bank address |
| q_ras_n_o | output | 1 | Registered row strobe |
| q_cas_n_o | output | 1 | Registered column strobe |
| q_we_n_o | output | 1 | Registered write enable |
| q_cke_o | output | 2 | Registered clock-enable bits |
| q_odt_o | output | 2 | Registered termination-control bits |
| q_load_o | output | 1 | 1 for the cycle after the gated group was loaded |

## Verification
The bench builds the block with its default parameters: four ranks, 16 address bits, 3 bank bits, and two bits each for clock enable and termination. Four ranks let each chip select be driven alone to open the gate. The full-width address and bank fields allow distinct patterns, such as all-ones, alternating bits and arbitrary words, so that a held value can be told apart from a newly loaded one. The two-bit clock-enable and termination fields show that they keep updating while the gated group is frozen.

// File: rtl/cs_gated_cmd_reg_pkg.sv
`timescale 1ns/1ps
package cs_gated_cmd_reg_pkg;

    parameter int unsigned RANKS  = 4;
    parameter int unsigned ADDR_W = 16;
    parameter int unsigned BANK_W = 3;
    parameter int unsigned CKE_W  = 2;
    parameter int unsigned ODT_W  = 2;

    localparam int unsigned GATED_W   = ADDR_W + BANK_W + 3;
    localparam int unsigned UNGATED_W = RANKS + CKE_W + ODT_W;

    // Address and command group: loads only on selected edges when gating is on
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
    } gated_t;

    // Group that loads on every edge
    typedef struct packed {
        logic [RANKS-1:0] cs_n;
        logic [CKE_W-1:0] cke;
        logic [ODT_W-1:0] odt;
    } ungated_t;

    typedef enum logic [1:0] {
        LD_HOLD   = 2'd0,
        LD_SELECT = 2'd1,
        LD_FREE   = 2'd2
    } load_cause_e;

    function automatic logic any_rank_selected(input logic [RANKS-1:0] cs_n);
        return ~&cs_n;
    endfunction

    function automatic load_cause_e classify(input logic gate_en,
                                             input logic [RANKS-1:0] cs_n);
        if (!gate_en)
            return LD_FREE;
        else if (any_rank_selected(cs_n))
            return LD_SELECT;
        else
            return LD_HOLD;
    endfunction

endpackage

// File: rtl/cgr_reset_sync.sv
`timescale 1ns/1ps
module cgr_reset_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_o
);
    logic [STAGES-1:0] chain_q;

    // Asserts at once when rst_n falls; releases after STAGES clock edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '1;
        else
            chain_q <= {chain_q[STAGES-2:0], 1'b0};
    end

    assign rst_o = chain_q[STAGES-1];

endmodule

// File: rtl/cgr_load_ctrl.sv
`timescale 1ns/1ps
module cgr_load_ctrl
    import cs_gated_cmd_reg_pkg::*;
(
    input  logic             gate_en_i,
    input  logic [RANKS-1:0] cs_n_i,
    output logic             load_o
);
    load_cause_e cause;

    always_comb begin
        cause  = classify(gate_en_i, cs_n_i);
        load_o = (cause != LD_HOLD);
    end

endmodule

// File: rtl/cgr_gated_bank.sv
`timescale 1ns/1ps
module cgr_gated_bank
    import cs_gated_cmd_reg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  gated_t d_i,
    output gated_t q_o,
    output logic   loaded_o
);
    logic [GATED_W-1:0] d_bits;
    logic [GATED_W-1:0] q_bits;

    assign d_bits = d_i;

    genvar b;
    generate
        for (b = 0; b < GATED_W; b++) begin : g_bit
            always_ff @(posedge clk or posedge rst) begin
                if (rst)
                    q_bits[b] <= 1'b0;
                else if (load_i)
                    q_bits[b] <= d_bits[b];
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            loaded_o <= 1'b0;
        else
            loaded_o <= load_i;
    end

    assign q_o = q_bits;

    // R1
    gated_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (q_o == $past(d_i)));

    // R2
    gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_o));

    // R8
    load_flag_chk: assert property (@(posedge clk) disable iff (rst)
        loaded_o |-> (q_o == $past(d_i)));

endmodule

// File: rtl/cgr_free_bank.sv
`timescale 1ns/1ps
module cgr_free_bank
    import cs_gated_cmd_reg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ungated_t d_i,
    output ungated_t q_o
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            q_o <= '0;
        else
            q_o <= d_i;
    end

    // R5
    free_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q_o == $past(d_i)));

endmodule

// File: rtl/cs_gated_cmd_reg.sv
`timescale 1ns/1ps
module cs_gated_cmd_reg
    import cs_gated_cmd_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en_i,
    input  logic [RANKS-1:0]  cs_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [CKE_W-1:0]  cke_i,
    input  logic [ODT_W-1:0]  odt_i,
    output logic [RANKS-1:0]  q_cs_n_o,
    output logic [ADDR_W-1:0] q_addr_o,
    output logic [BANK_W-1:0] q_bank_o,
    output logic              q_ras_n_o,
    output logic              q_cas_n_o,
    output logic              q_we_n_o,
    output logic [CKE_W-1:0]  q_cke_o,
    output logic [ODT_W-1:0]  q_odt_o,
    output logic              q_load_o
);
    logic     rst;
    logic     load;
    gated_t   g_d, g_q;
    ungated_t u_d, u_q;

    cgr_reset_sync #(.STAGES(2)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .rst_o (rst)
    );

    cgr_load_ctrl u_ctrl (
        .gate_en_i (gate_en_i),
        .cs_n_i    (cs_n_i),
        .load_o    (load)
    );

    always_comb begin
        g_d.addr  = addr_i;
        g_d.bank  = bank_i;
        g_d.ras_n = ras_n_i;
        g_d.cas_n = cas_n_i;
        g_d.we_n  = we_n_i;
        u_d.cs_n  = cs_n_i;
        u_d.cke   = cke_i;
        u_d.odt   = odt_i;
    end

    cgr_gated_bank u_gated (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .d_i      (g_d),
        .q_o      (g_q),
        .loaded_o (q_load_o)
    );

    cgr_free_bank u_free (
        .clk (clk),
        .rst (rst),
        .d_i (u_d),
        .q_o (u_q)
    );

    assign q_addr_o  = g_q.addr;
    assign q_bank_o  = g_q.bank;
    assign q_ras_n_o = g_q.ras_n;
    assign q_cas_n_o = g_q.cas_n;
    assign q_we_n_o  = g_q.we_n;
    assign q_cs_n_o  = u_q.cs_n;
    assign q_cke_o   = u_q.cke;
    assign q_odt_o   = u_q.odt;

    // R6
    reset_low_chk: assert property (@(posedge clk)
        rst |-> (g_q == '0 && u_q == '0 && !q_load_o));

    // R4
    free_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_en_i |=> q_load_o);

endmodule

// File: tb/cs_gated_cmd_reg_tb.sv
`timescale 1ns/1ps
module cs_gated_cmd_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        gate_en;
    logic [3:0]  cs_n;
    logic [15:0] addr;
    logic [2:0]  bank;
    logic        ras_n, cas_n, we_n;
    logic [1:0]  cke, odt;
    logic [3:0]  q_cs_n;
    logic [15:0] q_addr;
    logic [2:0]  q_bank;
    logic        q_ras_n, q_cas_n, q_we_n;
    logic [1:0]  q_cke, q_odt;
    logic        q_load;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    cs_gated_cmd_reg u_dut (
        .clk(clk), .rst_n(rst_n), .gate_en_i(gate_en), .cs_n_i(cs_n),
        .addr_i(addr), .bank_i(bank), .ras_n_i(ras_n), .cas_n_i(cas_n),
        .we_n_i(we_n), .cke_i(cke), .odt_i(odt),
        .q_cs_n_o(q_cs_n), .q_addr_o(q_addr), .q_bank_o(q_bank),
        .q_ras_n_o(q_ras_n), .q_cas_n_o(q_cas_n), .q_we_n_o(q_we_n),
        .q_cke_o(q_cke), .q_odt_o(q_odt), .q_load_o(q_load)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] gated_out();
        return {q_addr, q_bank, q_ras_n, q_cas_n, q_we_n};
    endfunction

    function automatic logic [7:0] free_out();
        return {q_cs_n, q_cke, q_odt};
    endfunction

    // Drive at the falling edge, then sample 2 ns after the next rising edge
    task automatic step(input logic en, input logic [3:0] cs, input logic [15:0] a,
                        input logic [2:0] b, input logic [2:0] cmd,
                        input logic [1:0] ck, input logic [1:0] od);
        @(negedge clk);
        gate_en = en; cs_n = cs; addr = a; bank = b;
        {ras_n, cas_n, we_n} = cmd; cke = ck; odt = od;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic t_reset_state();
        check("R6 reset gated", {42'd0, gated_out()}, 64'd0);
        check("R6 reset free", {56'd0, free_out()}, 64'd0);
        check("R6 reset flag", {63'd0, q_load}, 64'd0);
    endtask

    task automatic t_sync_release();
        @(negedge clk);
        rst_n = 1'b0;
        gate_en = 1'b0; cs_n = 4'hF; addr = 16'hFFFF; bank = 3'h7;
        {ras_n, cas_n, we_n} = 3'b111; cke = 2'b11; odt = 2'b11;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R7 first edge after release gated", {42'd0, gated_out()}, 64'd0);
        check("R7 first edge after release free", {56'd0, free_out()}, 64'd0);
        @(posedge clk);
        @(posedge clk);
        #2;
        check("R7 capture after release", {42'd0, gated_out()}, {42'd0, 22'h3FFFFF});
    endtask

    task automatic t_gated_load();
        step(1'b1, 4'b1110, 16'hA5C3, 3'h5, 3'b010, 2'b01, 2'b10);
        check("R1 load addr", {48'd0, q_addr}, {48'd0, 16'hA5C3});
        check("R1 load bank/cmd", {58'd0, q_bank, q_ras_n, q_cas_n, q_we_n}, {58'd0, 3'h5, 3'b010});
        check("R8 flag after load", {63'd0, q_load}, 64'd1);
    endtask

    task automatic t_gated_hold();
        step(1'b1, 4'b1111, 16'h1234, 3'h2, 3'b101, 2'b10, 2'b01);
        check("R2 hold gated", {42'd0, gated_out()}, {42'd0, 16'hA5C3, 3'h5, 3'b010});
        check("R5 free updates while held", {56'd0, free_out()}, {56'd0, 4'b1111, 2'b10, 2'b01});
        check("R8 flag after hold", {63'd0, q_load}, 64'd0);
        step(1'b1, 4'b1111, 16'h5555, 3'h1, 3'b000, 2'b00, 2'b11);
        check("R2 hold second edge", {48'd0, q_addr}, {48'd0, 16'hA5C3});
        check("R5 free second edge", {56'd0, free_out()}, {56'd0, 4'b1111, 2'b00, 2'b11});
    endtask

    task automatic t_each_rank();
        for (int r = 0; r < 4; r++) begin
            logic [3:0]  cs;
            logic [15:0] a;
            cs = 4'hF;
            cs[r] = 1'b0;
            a = 16'h0F00 + 16'(r * 17);
            step(1'b1, 4'hF, 16'hDEAD, 3'h0, 3'b111, 2'b00, 2'b00);
            step(1'b1, cs, a, 3'(r), 3'b011, 2'b11, 2'b00);
            check($sformatf("R3 rank %0d opens gate", r), {48'd0, q_addr}, {48'd0, a});
            check($sformatf("R3 rank %0d cs out", r), {60'd0, q_cs_n}, {60'd0, cs});
        end
    endtask

    task automatic t_gate_off();
        step(1'b0, 4'b1111, 16'h8001, 3'h6, 3'b100, 2'b01, 2'b01);
        check("R4 gating off loads", {42'd0, gated_out()}, {42'd0, 16'h8001, 3'h6, 3'b100});
        check("R4 flag gating off", {63'd0, q_load}, 64'd1);
        step(1'b0, 4'b1111, 16'h7FFE, 3'h1, 3'b001, 2'b10, 2'b00);
        check("R4 gating off second edge", {48'd0, q_addr}, {48'd0, 16'h7FFE});
        check("R5 free with gating off", {56'd0, free_out()}, {56'd0, 4'b1111, 2'b10, 2'b00});
    endtask

    task automatic t_async_reset();
        step(1'b1, 4'b0000, 16'hFFFF, 3'h7, 3'b111, 2'b11, 2'b11);
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R6 async clear gated", {42'd0, gated_out()}, 64'd0);
        check("R6 async clear free", {56'd0, free_out()}, 64'd0);
        check("R6 async clear flag", {63'd0, q_load}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        gate_en = 1'b1; cs_n = 4'hF; addr = '0; bank = '0;
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = '0; odt = '0;
        repeat (2) @(posedge clk);
        #2;
        t_reset_state();
        do_reset();
        t_gated_load();
        t_gated_hold();
        t_each_rank();
        t_gate_off();
        t_async_reset();
        t_sync_release();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule